// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit with Overflow Flags

This unit performs the 16-bit register-pair operations of a small 8-bit processor: a double-width subtraction, an arithmetic right shift, a rotate through carry and two offset-add loads. The surrounding core keeps the register file. It presents the BC, DE, HL and SP pair values, the current flag byte, an opcode and an optional immediate byte, and raises a one-cycle execute strobe.

One clock later the unit returns the new HL or DE value, the new flag byte, write strobes for the affected pair, the state count of the instruction and a done pulse. The outputs keep their values until the next strobe. Flags that an operation does not touch are copied from the incoming flag byte.

The flag byte has this layout: S in bit 7, Z in bit 6, X5 in bit 5, AC in bit 4, an unused bit 3, P in bit 2, V in bit 1 and CY in bit 0. V is a two's-complement overflow bit. X5 is a majority of the operand and result signs.

Top module: `rp_exec_unit`

## Requirements
- R1: While rst_n is low, hl_o, de_o, flags_o, states_o, hl_we_o, de_we_o and done_o are all zero.
- R2: done_o is high in exactly the cycle after each cycle in which exec_i was sampled high, and low otherwise. Without a strobe, hl_o, de_o, flags_o, states_o and both write strobes hold their values.
- R3: Opcode 08h sets hl_o = (HL - BC) mod 2^16. It sets CY (bit 0) when HL < BC as unsigned values, Z (bit 6) when the 16-bit result is zero, S (bit 7) to result bit 15, and P (bit 2) when the low result byte has an even number of ones.
- R4: For opcode 08h, AC (bit 4) is set when HL[3:0] < BC[3:0] as unsigned values.
- R5: For opcode 08h, V (bit 1) is set when the signed 16-bit difference HL - BC lies outside -32768..32767.
- R6: For opcode 08h, X5 (bit 5) is set when at least two of these are 1: HL bit 15, the inverse of BC bit 15, and result bit 15.
- R7: Opcode 10h sets hl_o = {HL[15], HL[15:1]} and CY = HL[0]. All other flag bits are copied from flags_i.
- R8: Opcode 18h sets de_o = {DE[14:0], old CY}, CY = DE[15] and V = DE[15] XOR DE[14]. All other flag bits are copied.
- R9: Opcode 28h sets de_o = (HL + zero-extended immediate) mod 2^16, and flags_o equals flags_i.
- R10: Opcode 38h sets de_o = (SP + zero-extended immediate) mod 2^16, and flags_o equals flags_i.
- R11: Any other opcode gives hl_o = hl_i, de_o = de_i and flags_o = flags_i, with both write strobes low and states_o = 0.
- R12: hl_we_o is high only for opcodes 08h and 10h. de_we_o is high only for opcodes 18h, 28h and 38h. The two are never high together.
- R13: states_o reports 10 for opcodes 08h, 18h, 28h and 38h, and 7 for opcode 10h.
- R14: Flag bit 3 is always copied unchanged from flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe |
| opcode_i | input | 8 | Operation code |
| imm_i | input | 8 | Immediate offset byte |
| bc_i | input | 16 | BC pair value |
| de_i | input | 16 | DE pair value |
| hl_i | input | 16 | HL pair value |
| sp_i | input | 16 | SP value |
| flags_i | input | 8 | Current flag byte |
| hl_o | output | 16 | Resulting HL |
| de_o | output | 16 | Resulting DE |
| flags_o | output | 8 | Resulting flag byte |
| hl_we_o | output | 1 | HL write strobe |
| de_we_o | output | 1 | DE write strobe |
| states_o | output | 4 | State count of the executed opcode |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The subtraction is tried with equal operands, which isolates Z. A small value minus a larger one separates the borrow and low-nibble borrow from the sign. Operand pairs that cross the signed limits in both directions separate V from CY and give X5 both polarities. The shift and rotate use patterns with bit 15, bit 14 and bit 0 set in different combinations, so the copied sign, the carry path and the V of the rotate can each be told apart. The offset loads use bases near FFFFh to expose wrap and zero extension. Unlisted opcodes and idle cycles show that nothing else changes.

// File: rtl/rp_exec_pkg.sv
package rp_exec_pkg;
  localparam int PAIR_W = 16;
  localparam int FL_W   = 8;

  localparam int FL_CY = 0;
  localparam int FL_V  = 1;
  localparam int FL_P  = 2;
  localparam int FL_AC = 4;
  localparam int FL_X5 = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DSUB,
    OP_ASHR,
    OP_ROTL,
    OP_OFS_HL,
    OP_OFS_SP
  } op_e;

  function automatic logic even_par(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic signed_ovf_sub(input logic a_s, input logic b_s, input logic r_s);
    return (a_s ^ b_s) & (r_s ^ a_s);
  endfunction
endpackage

// File: rtl/rp_exec_decode.sv
module rp_exec_decode
  import rp_exec_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic [7:0]         opcode,
  output op_e                op,
  output logic [STATE_W-1:0] states
);
  always_comb begin
    op     = OP_NONE;
    states = '0;
    unique case (opcode)
      8'h08: begin op = OP_DSUB;   states = STATE_W'(10); end
      8'h10: begin op = OP_ASHR;   states = STATE_W'(7);  end
      8'h18: begin op = OP_ROTL;   states = STATE_W'(10); end
      8'h28: begin op = OP_OFS_HL; states = STATE_W'(10); end
      8'h38: begin op = OP_OFS_SP; states = STATE_W'(10); end
      default: begin op = OP_NONE; states = '0; end
    endcase
  end
endmodule

// File: rtl/rp_exec_path.sv
module rp_exec_path
  import rp_exec_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  op_e               op,
  input  logic [PAIR_W-1:0] bc,
  input  logic [PAIR_W-1:0] de,
  input  logic [PAIR_W-1:0] hl,
  input  logic [PAIR_W-1:0] sp,
  input  logic [IMM_W-1:0]  imm,
  input  logic [FL_W-1:0]   fl_in,
  output logic [PAIR_W-1:0] hl_new,
  output logic [PAIR_W-1:0] de_new,
  output logic [FL_W-1:0]   fl_val,
  output logic [FL_W-1:0]   fl_mask,
  output logic              hl_we,
  output logic              de_we,
  output logic              sub_borrow,
  output logic              sub_ovf,
  output logic              sub_x5
);
  localparam int MSB = PAIR_W - 1;

  logic [PAIR_W:0]   diff;
  logic [4:0]        nib;
  logic [PAIR_W-1:0] ofs_base;
  logic [PAIR_W-1:0] ofs_sum;

  assign diff       = {1'b0, hl} - {1'b0, bc};
  assign nib        = {1'b0, hl[3:0]} - {1'b0, bc[3:0]};
  assign sub_borrow = diff[PAIR_W];
  assign sub_ovf    = signed_ovf_sub(hl[MSB], bc[MSB], diff[MSB]);
  assign sub_x5     = maj3(hl[MSB], ~bc[MSB], diff[MSB]);

  assign ofs_base = (op == OP_OFS_SP) ? sp : hl;
  assign ofs_sum  = ofs_base + {{(PAIR_W-IMM_W){1'b0}}, imm};

  always_comb begin
    hl_new  = hl;
    de_new  = de;
    fl_val  = '0;
    fl_mask = '0;
    hl_we   = 1'b0;
    de_we   = 1'b0;
    unique case (op)
      OP_DSUB: begin
        hl_new        = diff[MSB:0];
        hl_we         = 1'b1;
        fl_val[FL_S]  = diff[MSB];
        fl_val[FL_Z]  = (diff[MSB:0] == '0);
        fl_val[FL_X5] = sub_x5;
        fl_val[FL_AC] = nib[4];
        fl_val[FL_P]  = even_par(diff[7:0]);
        fl_val[FL_V]  = sub_ovf;
        fl_val[FL_CY] = sub_borrow;
        fl_mask       = '1;
        fl_mask[3]    = 1'b0;
      end
      OP_ASHR: begin
        hl_new         = {hl[MSB], hl[MSB:1]};
        hl_we          = 1'b1;
        fl_val[FL_CY]  = hl[0];
        fl_mask[FL_CY] = 1'b1;
      end
      OP_ROTL: begin
        de_new         = {de[MSB-1:0], fl_in[FL_CY]};
        de_we          = 1'b1;
        fl_val[FL_CY]  = de[MSB];
        fl_val[FL_V]   = de[MSB] ^ de[MSB-1];
        fl_mask[FL_CY] = 1'b1;
        fl_mask[FL_V]  = 1'b1;
      end
      OP_OFS_HL, OP_OFS_SP: begin
        de_new = ofs_sum;
        de_we  = 1'b1;
      end
      default: begin
        hl_new = hl;
        de_new = de;
      end
    endcase
  end
endmodule

// File: rtl/rp_flag_merge.sv
module rp_flag_merge #(
  parameter int FW = 8
) (
  input  logic [FW-1:0] fl_in,
  input  logic [FW-1:0] fl_val,
  input  logic [FW-1:0] fl_mask,
  output logic [FW-1:0] fl_out
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    assign fl_out[i] = fl_mask[i] ? fl_val[i] : fl_in[i];
  end
endmodule

// File: rtl/rp_exec_unit.sv
module rp_exec_unit
  import rp_exec_pkg::*;
#(
  parameter int IMM_W   = 8,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic [7:0]         opcode_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [PAIR_W-1:0]  bc_i,
  input  logic [PAIR_W-1:0]  de_i,
  input  logic [PAIR_W-1:0]  hl_i,
  input  logic [PAIR_W-1:0]  sp_i,
  input  logic [FL_W-1:0]    flags_i,
  output logic [PAIR_W-1:0]  hl_o,
  output logic [PAIR_W-1:0]  de_o,
  output logic [FL_W-1:0]    flags_o,
  output logic               hl_we_o,
  output logic               de_we_o,
  output logic [STATE_W-1:0] states_o,
  output logic               done_o
);
  op_e               op;
  logic [STATE_W-1:0] states_c;
  logic [PAIR_W-1:0] hl_c, de_c;
  logic [FL_W-1:0]   fl_val, fl_mask, fl_c;
  logic              hl_we_c, de_we_c;
  logic              sub_borrow, sub_ovf, sub_x5;

  rp_exec_decode #(.STATE_W(STATE_W)) u_dec (
    .opcode (opcode_i),
    .op     (op),
    .states (states_c)
  );

  rp_exec_path #(.IMM_W(IMM_W)) u_path (
    .op         (op),
    .bc         (bc_i),
    .de         (de_i),
    .hl         (hl_i),
    .sp         (sp_i),
    .imm        (imm_i),
    .fl_in      (flags_i),
    .hl_new     (hl_c),
    .de_new     (de_c),
    .fl_val     (fl_val),
    .fl_mask    (fl_mask),
    .hl_we      (hl_we_c),
    .de_we      (de_we_c),
    .sub_borrow (sub_borrow),
    .sub_ovf    (sub_ovf),
    .sub_x5     (sub_x5)
  );

  rp_flag_merge #(.FW(FL_W)) u_merge (
    .fl_in   (flags_i),
    .fl_val  (fl_val),
    .fl_mask (fl_mask),
    .fl_out  (fl_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl_o     <= '0;
      de_o     <= '0;
      flags_o  <= '0;
      hl_we_o  <= 1'b0;
      de_we_o  <= 1'b0;
      states_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= exec_i;
      if (exec_i) begin
        hl_o     <= hl_c;
        de_o     <= de_c;
        flags_o  <= fl_c;
        hl_we_o  <= hl_we_c;
        de_we_o  <= de_we_c;
        states_o <= states_c;
      end
    end
  end
endmodule

// File: rtl/rp_exec_chk.sv
module rp_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_i,
  input logic [7:0]  opcode_i,
  input logic [7:0]  flags_i,
  input logic [15:0] hl_i,
  input logic [15:0] hl_o,
  input logic [7:0]  flags_o,
  input logic        hl_we_o,
  input logic        de_we_o,
  input logic        done_o,
  input logic        sub_borrow,
  input logic        sub_ovf
);
  // R2
  done_follows_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> done_o);
  // R2
  done_only_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> !done_o);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(hl_o) && $stable(flags_o)));
  // R12
  one_pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hl_we_o && de_we_o));
  // R14
  spare_bit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> flags_o[3] == $past(flags_i[3]));
  // R9
  ofs_hl_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 8'h28) |=> flags_o == $past(flags_i));
  // R7
  ashr_sign_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 8'h10) |=> (hl_o[15] == hl_o[14] && hl_we_o));
  // R3
  dsub_borrow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 8'h08) |=> flags_o[0] == $past(sub_borrow));
  // R5
  dsub_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 8'h08) |=> flags_o[1] == $past(sub_ovf));
  // R3
  dsub_hl_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && opcode_i == 8'h08 && !sub_borrow) |=> hl_o <= $past(hl_i));
endmodule

bind rp_exec_unit rp_exec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_i     (exec_i),
  .opcode_i   (opcode_i),
  .flags_i    (flags_i),
  .hl_i       (hl_i),
  .hl_o       (hl_o),
  .flags_o    (flags_o),
  .hl_we_o    (hl_we_o),
  .de_we_o    (de_we_o),
  .done_o     (done_o),
  .sub_borrow (sub_borrow),
  .sub_ovf    (sub_ovf)
);

// File: tb/rp_exec_unit_bench.sv
module rp_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  imm_i = '0;
  logic [15:0] bc_i = '0, de_i = '0, hl_i = '0, sp_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] hl_o, de_o;
  logic [7:0]  flags_o;
  logic        hl_we_o, de_we_o, done_o;
  logic [3:0]  states_o;

  int total = 0;
  int bad = 0;
  logic exp_done = 1'b0;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  rp_exec_unit u_rp_exec_unit (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
    .imm_i(imm_i), .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .sp_i(sp_i),
    .flags_i(flags_i), .hl_o(hl_o), .de_o(de_o), .flags_o(flags_o),
    .hl_we_o(hl_we_o), .de_we_o(de_we_o), .states_o(states_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) exp_done <= rst_n && exec_i;
  // R2: done compared on every clock
  always @(negedge clk) if (mon_on) check("R2 done", int'(done_o), int'(exp_done));

  function automatic int popc8(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int sgn16(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic run_op(input int op, input int imm, input int bc, input int de,
                        input int hl, input int sp, input int fl);
    int e_hl, e_de, e_fl, e_hw, e_dw, e_st;
    int d, r, s, z, p, cy, ac, v, x5, sd, bit3;
    string tag;
    e_hl = hl; e_de = de; e_fl = fl; e_hw = 0; e_dw = 0; e_st = 0;
    bit3 = (fl >> 3) & 1;
    tag = "R11";
    case (op)
      8'h08: begin
        tag = "R3";
        d  = hl - bc;
        cy = (d < 0) ? 1 : 0;
        r  = d & 16'hFFFF;
        z  = (r == 0) ? 1 : 0;
        s  = (r >= 32768) ? 1 : 0;
        p  = (popc8(r & 255) % 2 == 0) ? 1 : 0;
        ac = ((hl & 15) < (bc & 15)) ? 1 : 0;
        sd = sgn16(hl) - sgn16(bc);
        v  = (sd > 32767 || sd < -32768) ? 1 : 0;
        x5 = ((((hl >= 32768) ? 1 : 0) + ((bc < 32768) ? 1 : 0) + s) >= 2) ? 1 : 0;
        e_hl = r; e_hw = 1; e_st = 10;
        e_fl = (s << 7) | (z << 6) | (x5 << 5) | (ac << 4) | (bit3 << 3) | (p << 2) | (v << 1) | cy;
      end
      8'h10: begin
        tag = "R7";
        e_hl = (hl / 2) + (hl & 32768);
        e_fl = (fl & 8'hFE) | (hl & 1);
        e_hw = 1; e_st = 7;
      end
      8'h18: begin
        tag = "R8";
        e_de = ((de * 2) & 16'hFFFF) | (fl & 1);
        cy = (de >> 15) & 1;
        v  = cy ^ ((de >> 14) & 1);
        e_fl = (fl & 8'hFC) | (v << 1) | cy;
        e_dw = 1; e_st = 10;
      end
      8'h28: begin tag = "R9";  e_de = (hl + imm) % 65536; e_dw = 1; e_st = 10; end
      8'h38: begin tag = "R10"; e_de = (sp + imm) % 65536; e_dw = 1; e_st = 10; end
      default: ;
    endcase
    @(negedge clk);
    opcode_i = 8'(op); imm_i = 8'(imm); bc_i = 16'(bc); de_i = 16'(de);
    hl_i = 16'(hl); sp_i = 16'(sp); flags_i = 8'(fl); exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    check({tag, " hl"}, int'(hl_o), e_hl);
    check({tag, " de"}, int'(de_o), e_de);
    check({tag, " flags"}, int'(flags_o), e_fl);
    check("R12 we", int'({hl_we_o, de_we_o}), e_hw * 2 + e_dw);
    check("R13 states", int'(states_o), e_st);
    check("R14 bit3", int'(flags_o[3]), bit3);
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h0, f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hl", int'(hl_o), 0);
    check("R1 flags", int'(flags_o), 0);
    check("R1 ctl", int'({hl_we_o, de_we_o, states_o, done_o}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R3 R4 R5 R6 subtraction patterns
    run_op(8'h08, 0, 16'h1234, 16'h0101, 16'h1234, 0, 8'h00);
    run_op(8'h08, 0, 16'h0001, 16'h0000, 16'h0000, 0, 8'h08);
    run_op(8'h08, 0, 16'h0001, 16'h0000, 16'h8000, 0, 8'hFF);
    run_op(8'h08, 0, 16'hFFFF, 16'h0000, 16'h7FFF, 0, 8'h00);
    run_op(8'h08, 0, 16'h0F0F, 16'h0000, 16'h3003, 0, 8'h00);
    // R7 shift
    run_op(8'h10, 0, 0, 0, 16'h8001, 0, 8'h00);
    run_op(8'h10, 0, 0, 0, 16'h4102, 0, 8'hFF);
    // R8 rotate
    run_op(8'h18, 0, 0, 16'h4080, 0, 0, 8'h01);
    run_op(8'h18, 0, 0, 16'hC000, 0, 0, 8'h00);
    run_op(8'h18, 0, 0, 16'h8000, 0, 0, 8'hF6);
    // R9 R10 offset loads with wrap
    run_op(8'h28, 8'hFF, 0, 16'h1111, 16'hFFF0, 16'h2222, 8'hA5);
    run_op(8'h28, 8'h80, 0, 16'h1111, 16'h0100, 16'h2222, 8'h5A);
    run_op(8'h38, 8'h02, 0, 16'h1111, 16'h3333, 16'hFFFF, 8'h3C);
    run_op(8'h38, 8'hC0, 0, 16'h1111, 16'h3333, 16'h1000, 8'h00);
    // R11 unlisted opcodes
    run_op(8'h00, 8'h12, 16'h1, 16'hABCD, 16'h5678, 16'h9, 8'hC3);
    run_op(8'hCB, 8'h12, 16'h1, 16'h0F0F, 16'hF0F0, 16'h9, 8'h3C);
    for (int k = 0; k < 40; k++) begin
      int ops[5] = '{8'h08, 8'h10, 8'h18, 8'h28, 8'h38};
      run_op(ops[k % 5], int'($urandom_range(255)), int'($urandom_range(65535)),
             int'($urandom_range(65535)), int'($urandom_range(65535)),
             int'($urandom_range(65535)), int'($urandom_range(255)));
    end
    // R2 hold while idle and inputs move
    h0 = int'(hl_o); f0 = int'(flags_o);
    hl_i = ~hl_i; flags_i = ~flags_i; opcode_i = 8'h08;
    repeat (3) @(negedge clk);
    check("R2 hold hl", int'(hl_o), h0);
    check("R2 hold flags", int'(flags_o), f0);
    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule